// File: doc/BRIEF.md
# Stop-Mode Power Supervisor Controller

This controller moves a microcontroller between normal execution and a low-power stop state, and decides when a supply monitor runs. It reads three digital comparator outputs: supply below the warning level, supply below the reset level, and supply below the power-on level. It also reads an I/O interrupt request, a single-cycle pulse from a slow 8 kHz time base, a software stop request, and a bit that lets the monitor be switched off during stop. It drives the monitor enable, a CPU run/hold signal, an active-high internal reset and a sticky power-fail flag.

During execution the monitor is always enabled. A warning dip sets the flag only if it lasts at least a programmable number of clocks. A reset-level dip resets the CPU. During stop, the monitor can be turned off, and warning and reset-level conditions are then ignored. The power-on comparator always forces a reset. Any wake-up first re-enables the monitor and waits a fixed number of slow ticks. It then samples the comparators and either resumes execution, resumes with the flag set, or holds the CPU in reset. A wake-up timer, loaded when stop is entered and counted on slow ticks, is one of the wake sources.

Top module: `pss_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `int_rst`=1, `cpu_run`=0, `mon_en`=1 and `pf_flag`=0.
- R2: Stop is entered only through a one-cycle `stop_req` pulse while running. `cpu_run` is 0 on the clock after the pulse, and stays 1 without a pulse.
- R3: `mon_en` is 1 whenever the CPU runs. While stopped it equals the inverse of `mon_dis`.
- R4: While stopped with `mon_dis`=1, `cmp_warn` and `cmp_rst` have no effect. The CPU stays stopped with `int_rst`=0 and `pf_flag` unchanged.
- R5: `cmp_por`=1 in any state gives `int_rst`=1, `cpu_run`=0 and `pf_flag`=0 on the next clock.
- R6: `io_irq` ends stop. A nonzero `wake_cnt`, captured at stop entry, ends stop on the `wake_cnt`-th `tick` after entry. A value of zero never ends stop.
- R7: After a wake-up, `mon_en`=1 and `cpu_run`=0 until the `SETTLE_TICKS`-th `tick`. The comparators are sampled in that cycle: if `cmp_warn`=1 and `cmp_rst`=0, the CPU runs with `pf_flag` set.
- R8: If `cmp_rst`=1 at the settle sample, `int_rst`=1 instead of execution resuming.
- R9: While running, `cmp_warn` high for at least `FILT_CLKS` consecutive clocks sets `pf_flag`. Shorter runs do not.
- R10: `pf_flag` stays set until a `flag_clr` pulse. A set condition in the same cycle as `flag_clr` wins.
- R11: `cmp_rst`=1 while running gives `int_rst`=1 on the next clock. Reset is released, and the CPU runs, `RST_HOLD` clocks after both `cmp_rst` and `cmp_por` are low.
- R12: While stopped with `mon_dis`=0, `cmp_warn` or `cmp_rst` ends stop and starts the settle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per 8 kHz period |
| stop_req | input | 1 | Software request to enter stop |
| mon_dis | input | 1 | 1: monitor off while stopped |
| wake_cnt | input | WAKE_W | Wake-up timer length in ticks, 0 = off |
| io_irq | input | 1 | External I/O interrupt request |
| cmp_warn | input | 1 | Supply below warning level |
| cmp_rst | input | 1 | Supply below reset level |
| cmp_por | input | 1 | Supply below power-on level |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| mon_en | output | 1 | Supply monitor enable |
| cpu_run | output | 1 | 1: CPU executes, 0: held |
| int_rst | output | 1 | Internal reset, active high |
| pf_flag | output | 1 | Sticky power-fail warning flag |

## Verification
The bench builds the block with its default parameters: `FILT_CLKS`=8, `SETTLE_TICKS`=4, `RST_HOLD`=16 and a 16-bit wake count. With these values, the filter edge (7 clocks ignored, 8 set), the full settle window, the full reset hold and a 3-tick timer wake can each be stepped clock by clock in a short run. Because the tick input is driven directly, slow-clock intervals cost only a few system clocks. This makes the zero-count case, where the timer never wakes, cheap to check over many ticks.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RESET  = 2'd3
  } pss_state_e;
endpackage

// File: rtl/pss_step_cnt.sv
// Counts enabled steps up to LIMIT; last is high on the LIMIT-th step.
module pss_step_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last = step && !clear && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pss_warn_filter.sv
// Asserts hit on each cycle cmp is high, once it has been high FILT_CLKS cycles in a row.
module pss_warn_filter #(
  parameter int unsigned FILT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cmp,
  output logic hit
);
  localparam int unsigned CW = (FILT_CLKS > 1) ? $clog2(FILT_CLKS) : 1;
  localparam logic [CW-1:0] TOP = CW'(FILT_CLKS - 1);

  logic [CW-1:0] run_q;

  assign hit = en && cmp && (run_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !en || !cmp) run_q <= '0;
    else if (run_q != TOP) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/pss_wake_timer.sv
// Loaded at stop entry; expires on the programmed tick. Zero disables it.
module pss_wake_timer #(
  parameter int unsigned WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAKE_W-1:0] load_val,
  input  logic              en,
  input  logic              tick,
  output logic              expire
);
  logic [WAKE_W-1:0] rem_q;

  assign expire = en && tick && (rem_q == WAKE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (en && tick && (rem_q > WAKE_W'(1))) rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int unsigned FILT_CLKS    = 8,
  parameter int unsigned SETTLE_TICKS = 4,
  parameter int unsigned RST_HOLD     = 16,
  parameter int unsigned WAKE_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              stop_req,
  input  logic              mon_dis,
  input  logic [WAKE_W-1:0] wake_cnt,
  input  logic              io_irq,
  input  logic              cmp_warn,
  input  logic              cmp_rst,
  input  logic              cmp_por,
  input  logic              flag_clr,
  output logic              mon_en,
  output logic              cpu_run,
  output logic              int_rst,
  output logic              pf_flag
);
  pss_state_e state_q, state_n;
  logic filt_hit, wake_exp, settle_done, hold_done;
  logic mon_live, stop_wake, settle_warn, flag_n;

  pss_warn_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
    .clk(clk), .rst(rst), .en(state_q == ST_RUN), .cmp(cmp_warn), .hit(filt_hit)
  );

  pss_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
    .clk(clk), .rst(rst),
    .load(state_q == ST_RUN && stop_req), .load_val(wake_cnt),
    .en(state_q == ST_STOP), .tick(tick), .expire(wake_exp)
  );

  pss_step_cnt #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst(rst), .clear(state_q != ST_SETTLE), .step(tick),
    .last(settle_done)
  );

  pss_step_cnt #(.LIMIT(RST_HOLD)) u_hold (
    .clk(clk), .rst(rst),
    .clear(state_q != ST_RESET || cmp_rst || cmp_por), .step(1'b1),
    .last(hold_done)
  );

  assign mon_live    = !mon_dis;
  assign stop_wake   = io_irq || wake_exp || (mon_live && (cmp_warn || cmp_rst));
  assign settle_warn = (state_q == ST_SETTLE) && settle_done && !cmp_rst && cmp_warn;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (cmp_rst) state_n = ST_RESET;
        else if (stop_req) state_n = ST_STOP;
      end
      ST_STOP:   if (stop_wake) state_n = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_n = cmp_rst ? ST_RESET : ST_RUN;
      ST_RESET:  if (hold_done) state_n = ST_RUN;
      default:   state_n = ST_RESET;
    endcase
    if (cmp_por) state_n = ST_RESET;
  end

  always_comb begin
    flag_n = pf_flag;
    if (flag_clr) flag_n = 1'b0;
    if (filt_hit || settle_warn) flag_n = 1'b1;
    if (cmp_por) flag_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET;
      mon_en  <= 1'b1;
      cpu_run <= 1'b0;
      int_rst <= 1'b1;
      pf_flag <= 1'b0;
    end else begin
      state_q <= state_n;
      mon_en  <= (state_n == ST_STOP) ? mon_live : 1'b1;
      cpu_run <= (state_n == ST_RUN);
      int_rst <= (state_n == ST_RESET);
      pf_flag <= flag_n;
    end
  end
endmodule

// File: rtl/pss_ctrl_chk.sv
module pss_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic stop_req,
  input logic cmp_rst,
  input logic cmp_por,
  input logic flag_clr,
  input logic mon_en,
  input logic cpu_run,
  input logic int_rst,
  input logic pf_flag
);
  p_run_mon_on_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_run |-> mon_en);

  p_rst_excl_run_r11: assert property (@(posedge clk) disable iff (rst)
    !(int_rst && cpu_run));

  p_por_reset_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_por |=> (int_rst && !cpu_run && !pf_flag));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pf_flag && !flag_clr && !cmp_por) |=> pf_flag);

  p_release_mon_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_run) |-> $past(mon_en));

  p_fell_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_run) |-> $past(stop_req || cmp_rst || cmp_por));
endmodule

bind pss_ctrl pss_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .stop_req(stop_req), .cmp_rst(cmp_rst),
  .cmp_por(cmp_por), .flag_clr(flag_clr), .mon_en(mon_en),
  .cpu_run(cpu_run), .int_rst(int_rst), .pf_flag(pf_flag)
);

// File: tb/pss_ctrl_tb.sv
module pss_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, tick, stop_req, mon_dis, io_irq;
  logic cmp_warn, cmp_rst, cmp_por, flag_clr;
  logic [15:0] wake_cnt;
  logic mon_en, cpu_run, int_rst, pf_flag;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pss_ctrl dut_i (
    .clk(clk), .rst(rst), .tick(tick), .stop_req(stop_req), .mon_dis(mon_dis),
    .wake_cnt(wake_cnt), .io_irq(io_irq), .cmp_warn(cmp_warn), .cmp_rst(cmp_rst),
    .cmp_por(cmp_por), .flag_clr(flag_clr), .mon_en(mon_en), .cpu_run(cpu_run),
    .int_rst(int_rst), .pf_flag(pf_flag)
  );

  typedef struct packed { logic [7:0] dur; logic exp; } vec_t;
  localparam vec_t VECS [0:4] = '{
    '{dur: 8'd1,  exp: 1'b0},
    '{dur: 8'd7,  exp: 1'b0},
    '{dur: 8'd8,  exp: 1'b1},
    '{dur: 8'd12, exp: 1'b1},
    '{dur: 8'd0,  exp: 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic warn_for(input int n);
    cmp_warn = 1'b1; clks(n); cmp_warn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; stop_req = 1'b0; mon_dis = 1'b1; io_irq = 1'b0;
    cmp_warn = 1'b0; cmp_rst = 1'b0; cmp_por = 1'b0; flag_clr = 1'b0;
    wake_cnt = 16'd0;
    clks(3);
    chk("R1 int_rst", int_rst, 1'b1);
    chk("R1 cpu_run", cpu_run, 1'b0);
    chk("R1 mon_en", mon_en, 1'b1);
    chk("R1 pf_flag", pf_flag, 1'b0);
    rst = 1'b0;
    clks(15);
    chk("R11 hold 15", int_rst, 1'b1);
    clks(1);
    chk("R11 released", int_rst, 1'b0);
    chk("R1 runs", cpu_run, 1'b1);
    chk("R3 mon in run", mon_en, 1'b1);

    // R9 warn filter table
    for (int i = 0; i < 5; i++) begin
      pulse_clr();
      warn_for(VECS[i].dur);
      clks(2);
      chk("R9 filter", pf_flag, VECS[i].exp);
    end

    // R10 sticky, clear, set wins
    chk("R10 sticky", pf_flag, 1'b0);
    warn_for(8); clks(5);
    chk("R10 sticky", pf_flag, 1'b1);
    pulse_clr(); clks(1);
    chk("R10 clear", pf_flag, 1'b0);
    cmp_warn = 1'b1; clks(9);
    flag_clr = 1'b1; clks(1); flag_clr = 1'b0; cmp_warn = 1'b0;
    chk("R10 set wins", pf_flag, 1'b1);
    pulse_clr();

    // R2 no request keeps running
    clks(5);
    chk("R2 stays run", cpu_run, 1'b1);
    mon_dis = 1'b1; wake_cnt = 16'd0;
    pulse_stop();
    chk("R2 stopped", cpu_run, 1'b0);
    chk("R2 no reset", int_rst, 1'b0);
    chk("R3 mon off", mon_en, 1'b0);

    // R4 ignored comparators, R6 zero timer
    cmp_warn = 1'b1; cmp_rst = 1'b1; clks(10);
    repeat (20) pulse_tick();
    chk("R4 still stopped", cpu_run, 1'b0);
    chk("R4 no reset", int_rst, 1'b0);
    chk("R4 flag", pf_flag, 1'b0);
    chk("R6 zero timer", mon_en, 1'b0);
    cmp_warn = 1'b0;
    io_irq = 1'b1; clks(1); io_irq = 1'b0;
    chk("R7 mon on settle", mon_en, 1'b1);
    chk("R7 held settle", cpu_run, 1'b0);
    repeat (3) pulse_tick();
    chk("R7 held 3 ticks", cpu_run, 1'b0);
    chk("R8 not yet reset", int_rst, 1'b0);
    pulse_tick();
    chk("R8 reset at exit", int_rst, 1'b1);
    chk("R8 no run", cpu_run, 1'b0);
    cmp_rst = 1'b0;
    clks(16);
    chk("R11 back to run", cpu_run, 1'b1);

    // R7 warning at exit sets flag
    pulse_stop();
    cmp_warn = 1'b1; clks(3);
    chk("R4 warn ignored", pf_flag, 1'b0);
    io_irq = 1'b1; clks(1); io_irq = 1'b0;
    repeat (3) pulse_tick();
    tick = 1'b1; clks(1); tick = 1'b0; cmp_warn = 1'b0;
    chk("R7 resumed", cpu_run, 1'b1);
    chk("R7 flag at exit", pf_flag, 1'b1);
    pulse_clr();

    // R6 timer wake after 3 ticks
    wake_cnt = 16'd3;
    pulse_stop();
    repeat (2) pulse_tick();
    chk("R6 before expiry", mon_en, 1'b0);
    pulse_tick();
    chk("R6 woke", mon_en, 1'b1);
    chk("R6 settling", cpu_run, 1'b0);
    repeat (4) pulse_tick();
    chk("R6 resumed", cpu_run, 1'b1);
    chk("R6 no flag", pf_flag, 1'b0);

    // R12 monitor live in stop
    wake_cnt = 16'd0; mon_dis = 1'b0;
    pulse_stop();
    chk("R3 mon live in stop", mon_en, 1'b1);
    clks(3);
    chk("R12 stopped", cpu_run, 1'b0);
    warn_for(1);
    repeat (3) pulse_tick();
    chk("R12 settling", cpu_run, 1'b0);
    pulse_tick();
    chk("R12 resumed", cpu_run, 1'b1);
    chk("R12 no flag", pf_flag, 1'b0);

    // R11 reset level while running
    cmp_rst = 1'b1; clks(1);
    chk("R11 run reset", int_rst, 1'b1);
    cmp_rst = 1'b0; clks(16);
    chk("R11 recovered", cpu_run, 1'b1);

    // R5 power-on reset in stop
    warn_for(8); clks(1);
    chk("R5 flag before", pf_flag, 1'b1);
    mon_dis = 1'b1;
    pulse_stop();
    cmp_por = 1'b1; clks(1);
    chk("R5 reset", int_rst, 1'b1);
    chk("R5 flag cleared", pf_flag, 1'b0);
    cmp_por = 1'b0; clks(16);
    chk("R5 recovered", cpu_run, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule